// File: doc/BRIEF.md
# Pass-Through Pulse Stripping Node

This block is one stage in a series chain of identical radar processing nodes that all see a single stream of back-to-back pulses. When a frame opens, the node keeps the leading pulse or pulses for its own compression pipeline and sends every later sample of the frame on to the next node, unchanged and in order. The next node then treats the first forwarded sample as the start of its own frame. No node needs to know its position in the chain.

The node also receives a reference stream alongside the channel stream. Each stream has a small alignment FIFO. The local output gives one channel sample paired with one reference sample. A pair is issued only when both FIFOs hold data, so a reference that arrives a few samples later than the channel is absorbed. The pulse length is selectable per frame. The number of pulses kept is also selectable per frame. Both settings are captured on the frame-start sample.

Back-pressure rules: the upstream channel and reference inputs carry real-time data, have no ready signal, and are never stalled. The local output has no ready signal; the local pipeline must take one pair per valid cycle. The downstream output follows valid/ready: a sample moves on any cycle where `ds_valid` and `ds_ready` are both high. While `ds_valid` is high and `ds_ready` is low, the data and the start flag hold. A stall affects only the forwarding FIFO. If that FIFO is full, a sample arriving for it is dropped and a sticky error flag is set.

Top module: `strip_node`

## Requirements
- R1: After reset, or a later reset, `loc_valid`, `loc_sop`, `ds_valid`, `ds_sof`, `err_fwd_ovf` and `err_align_ovf` are all 0.
- R2: A channel sample with `up_valid` and `up_sof` both high opens a frame and is sample index 0. Frame samples with index below the keep limit go to the local output, in arrival order.
- R3: Channel samples of an open frame at or past the keep limit leave on `ds_data`, unchanged and in order. `ds_sof` is 1 on the first of these in each frame and 0 on the rest.
- R4: `cfg_keep` = 0 keeps one pulse, and `cfg_keep` = 1 keeps two pulses. The keep limit is the pulse length times the pulses kept.
- R5: `cfg_len_sel` selects the pulse length as 2^(LEN_LOG2_MIN + s). s is 0, 1 or 2 for codes 0, 1 and 2, and code 3 acts like code 2.
- R6: `cfg_len_sel` and `cfg_keep` are captured on the frame-start sample. Changing them mid-frame has no effect on that frame.
- R7: A frame-start sample that arrives while a frame is open, in either its local or its forwarded part, restarts the count at index 0.
- R8: Channel samples before the first frame start after reset are discarded. Reference samples are taken only from a `ref_sof` sample up to the keep limit of that reference frame, and others are discarded.
- R9: Local pair k is channel local sample k with reference local sample k. It appears 2 clock edges after the later of the two samples was accepted. `loc_sop` is 1 on pairs whose channel index is a multiple of the pulse length.
- R10: While `ds_valid` is 1 and `ds_ready` is 0, the next cycle still shows `ds_valid` 1 with the same `ds_data` and `ds_sof`. Downstream stalls do not delay local pairs.
- R11: A sample bound downstream that meets a full forwarding FIFO is dropped. This happens even if a pop occurs in the same cycle. `err_fwd_ovf` then goes to 1 and stays 1 until reset.
- R12: A local channel or reference sample that meets a full alignment FIFO sets `err_align_ovf`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_sel | input | 2 | Pulse length code, captured at frame start |
| cfg_keep | input | 1 | 0 keeps one pulse, 1 keeps two |
| up_valid | input | 1 | Upstream channel sample present |
| up_sof | input | 1 | Upstream sample opens a frame |
| up_data | input | DW | Upstream channel sample |
| ref_valid | input | 1 | Reference sample present |
| ref_sof | input | 1 | Reference sample opens a reference frame |
| ref_data | input | DW | Reference sample |
| loc_valid | output | 1 | Local pair present |
| loc_sop | output | 1 | Local pair starts a pulse |
| loc_ch | output | DW | Local channel sample |
| loc_ref | output | DW | Local reference sample |
| ds_valid | output | 1 | Forwarded sample present |
| ds_ready | input | 1 | Downstream accepts the sample |
| ds_sof | output | 1 | Forwarded sample opens the next node's frame |
| ds_data | output | DW | Forwarded sample |
| err_fwd_ovf | output | 1 | Sticky forwarding-FIFO overflow |
| err_align_ovf | output | 1 | Sticky alignment-FIFO overflow |

## Verification
A local pair is due two edges after the later of its channel and reference samples is accepted. One edge writes the alignment FIFO and the next edge registers the pair. A forwarded sample is visible one edge after it is accepted. An error flag rises on the edge that drops a sample. The bench drives inputs on the falling edge and samples one time unit later. It checks that the first pair's cycle minus the channel drive cycle equals two plus the reference delay. Items are matched by order through scoreboards rather than by fixed timing.

// File: rtl/psn_pkg.sv
package psn_pkg;

  typedef enum logic [1:0] {
    LEN_BASE   = 2'd0,
    LEN_DOUBLE = 2'd1,
    LEN_QUAD   = 2'd2,
    LEN_QUAD_B = 2'd3
  } len_sel_e;

  // extra shift above the minimum pulse length for a length code
  function automatic int unsigned len_shift(input logic [1:0] code);
    len_sel_e c;
    c = len_sel_e'(code);
    case (c)
      LEN_BASE:   return 0;
      LEN_DOUBLE: return 1;
      default:    return 2;
    endcase
  endfunction

endpackage

// File: rtl/psn_fifo.sv
module psn_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/psn_frame_ctl.sv
module psn_frame_ctl
  import psn_pkg::*;
#(
  parameter int LEN_LOG2_MIN = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [1:0] cfg_len_sel,
  input  logic       cfg_keep,
  output logic       to_local,
  output logic       to_fwd,
  output logic       head
);
  localparam int IW = LEN_LOG2_MIN + 4;

  logic          open_q, fwd_first_q;
  logic [IW-1:0] idx_q, lim_q, mask_q;
  logic [IW-1:0] len_new, lim_new;

  assign len_new = IW'(1) << (LEN_LOG2_MIN + int'(len_shift(cfg_len_sel)));
  assign lim_new = cfg_keep ? (len_new << 1) : len_new;

  always_comb begin
    to_local = 1'b0;
    to_fwd   = 1'b0;
    head     = 1'b0;
    if (in_valid) begin
      if (in_sof) begin
        to_local = 1'b1;
        head     = 1'b1;
      end else if (open_q) begin
        if (idx_q < lim_q) begin
          to_local = 1'b1;
          head     = ((idx_q & mask_q) == '0);
        end else begin
          to_fwd = 1'b1;
          head   = fwd_first_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      fwd_first_q <= 1'b0;
      idx_q       <= '0;
      lim_q       <= '0;
      mask_q      <= '0;
    end else if (in_valid && in_sof) begin
      open_q      <= 1'b1;
      fwd_first_q <= 1'b1;
      idx_q       <= IW'(1);
      lim_q       <= lim_new;
      mask_q      <= len_new - 1'b1;
    end else begin
      if (to_local) idx_q <= idx_q + 1'b1;
      if (to_fwd)   fwd_first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/strip_node.sv
module strip_node #(
  parameter int LEN_LOG2_MIN = 14,
  parameter int DW           = 16,
  parameter int FWD_DEPTH    = 16,
  parameter int ALIGN_DEPTH  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_len_sel,
  input  logic          cfg_keep,
  input  logic          up_valid,
  input  logic          up_sof,
  input  logic [DW-1:0] up_data,
  input  logic          ref_valid,
  input  logic          ref_sof,
  input  logic [DW-1:0] ref_data,
  output logic          loc_valid,
  output logic          loc_sop,
  output logic [DW-1:0] loc_ch,
  output logic [DW-1:0] loc_ref,
  output logic          ds_valid,
  input  logic          ds_ready,
  output logic          ds_sof,
  output logic [DW-1:0] ds_data,
  output logic          err_fwd_ovf,
  output logic          err_align_ovf
);
  localparam int TW = DW + 1;

  logic ch_to_local, ch_to_fwd, ch_head;
  logic ref_to_local, ref_fwd_unused, ref_head_unused;

  psn_frame_ctl #(.LEN_LOG2_MIN(LEN_LOG2_MIN)) u_ch_ctl (
    .clk, .rst_n,
    .in_valid(up_valid), .in_sof(up_sof),
    .cfg_len_sel, .cfg_keep,
    .to_local(ch_to_local), .to_fwd(ch_to_fwd), .head(ch_head)
  );

  psn_frame_ctl #(.LEN_LOG2_MIN(LEN_LOG2_MIN)) u_ref_ctl (
    .clk, .rst_n,
    .in_valid(ref_valid), .in_sof(ref_sof),
    .cfg_len_sel, .cfg_keep,
    .to_local(ref_to_local), .to_fwd(ref_fwd_unused), .head(ref_head_unused)
  );

  // forwarding path
  logic          fwd_full, fwd_empty;
  logic [TW-1:0] fwd_dout;

  psn_fifo #(.W(TW), .DEPTH(FWD_DEPTH)) u_fwd_fifo (
    .clk, .rst_n,
    .push(ch_to_fwd), .pop(ds_ready),
    .din({ch_head, up_data}), .dout(fwd_dout),
    .empty(fwd_empty), .full(fwd_full)
  );

  assign ds_valid = !fwd_empty;
  assign ds_sof   = !fwd_empty && fwd_dout[DW];
  assign ds_data  = fwd_dout[DW-1:0];

  // alignment path
  logic          chq_full, chq_empty, refq_full, refq_empty, pair_go;
  logic [TW-1:0] chq_dout;
  logic [DW-1:0] refq_dout;

  assign pair_go = !chq_empty && !refq_empty;

  psn_fifo #(.W(TW), .DEPTH(ALIGN_DEPTH)) u_ch_fifo (
    .clk, .rst_n,
    .push(ch_to_local), .pop(pair_go),
    .din({ch_head, up_data}), .dout(chq_dout),
    .empty(chq_empty), .full(chq_full)
  );

  psn_fifo #(.W(DW), .DEPTH(ALIGN_DEPTH)) u_ref_fifo (
    .clk, .rst_n,
    .push(ref_to_local), .pop(pair_go),
    .din(ref_data), .dout(refq_dout),
    .empty(refq_empty), .full(refq_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_valid <= 1'b0;
      loc_sop   <= 1'b0;
      loc_ch    <= '0;
      loc_ref   <= '0;
    end else begin
      loc_valid <= pair_go;
      loc_sop   <= pair_go && chq_dout[DW];
      if (pair_go) begin
        loc_ch  <= chq_dout[DW-1:0];
        loc_ref <= refq_dout;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_fwd_ovf   <= 1'b0;
      err_align_ovf <= 1'b0;
    end else begin
      if (ch_to_fwd && fwd_full) err_fwd_ovf <= 1'b1;
      if ((ch_to_local && chq_full) || (ref_to_local && refq_full))
        err_align_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/psn_checker.sv
module psn_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic          up_sof,
  input logic          loc_valid,
  input logic          loc_sop,
  input logic          ds_valid,
  input logic          ds_ready,
  input logic          ds_sof,
  input logic [DW-1:0] ds_data,
  input logic          err_fwd_ovf,
  input logic          err_align_ovf
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (up_valid && up_sof) seen_q <= 1'b1;
  end

  AST_QUIET_BEFORE_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!loc_valid && !ds_valid)); // R8

  AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready) |=> (ds_valid && $stable(ds_data) && $stable(ds_sof))); // R10

  AST_FWD_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_fwd_ovf |=> err_fwd_ovf); // R11

  AST_ALIGN_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_align_ovf |=> err_align_ovf); // R12

  AST_LOC_SOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    loc_sop |-> loc_valid); // R9

  AST_DS_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ds_sof |-> ds_valid); // R3
endmodule

bind strip_node psn_checker #(.DW(DW)) u_chk (.*);

// File: tb/sim_strip_node.sv
module sim_strip_node;
  localparam int LMIN = 3;
  localparam int DW   = 16;
  localparam int FD   = 4;
  localparam int AD   = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_len_sel;
  logic          cfg_keep;
  logic          up_valid, up_sof, ref_valid, ref_sof;
  logic [DW-1:0] up_data, ref_data;
  logic          loc_valid, loc_sop, ds_valid, ds_ready, ds_sof;
  logic [DW-1:0] loc_ch, loc_ref, ds_data;
  logic          err_fwd_ovf, err_align_ovf;

  always #10 clk = ~clk;

  strip_node #(.LEN_LOG2_MIN(LMIN), .DW(DW), .FWD_DEPTH(FD), .ALIGN_DEPTH(AD)) u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  int loc_cnt = 0, ds_cnt = 0, first_loc = -1, drive0 = 0, rdy_mode = 0;

  typedef struct packed { logic sop; logic [DW-1:0] d; } item_t;
  item_t exp_ch[$], exp_ds[$];
  logic [DW-1:0] exp_ref[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    ds_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ((cyc % 3) != 0);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] chd(input int tag, input int i);
    return {8'(tag), 8'(i)};
  endfunction
  function automatic logic [DW-1:0] rfd(input int tag, input int i);
    return {~8'(tag), 8'(i * 3)};
  endfunction

  // monitor / scoreboard
  initial begin
    bit pv = 0, prdy = 0, psof = 0;
    logic [DW-1:0] pdata = '0;
    forever begin
      @(negedge clk); #1;
      if (!rst_n) begin pv = 0; continue; end
      if (pv && !prdy)
        chk(ds_valid && ds_data == pdata && ds_sof == psof, "R10", "stalled output held",
            int'(ds_data), int'(pdata));
      if (loc_valid) begin
        loc_cnt++;
        if (first_loc < 0) first_loc = cyc;
        if (exp_ch.size() == 0 || exp_ref.size() == 0)
          chk(0, "R2", "unexpected local pair", int'(loc_ch), -1);
        else begin
          item_t e; logic [DW-1:0] r;
          e = exp_ch.pop_front(); r = exp_ref.pop_front();
          chk(loc_ch == e.d, "R2", "local channel", int'(loc_ch), int'(e.d));
          chk(loc_ref == r, "R9", "local reference", int'(loc_ref), int'(r));
          chk(loc_sop == e.sop, "R9", "local pulse start", int'(loc_sop), int'(e.sop));
        end
      end
      if (ds_valid && ds_ready) begin
        ds_cnt++;
        if (exp_ds.size() == 0)
          chk(0, "R3", "unexpected forwarded sample", int'(ds_data), -1);
        else begin
          item_t e;
          e = exp_ds.pop_front();
          chk(ds_data == e.d, "R3", "forwarded data", int'(ds_data), int'(e.d));
          chk(ds_sof == e.sop, "R3", "forwarded start", int'(ds_sof), int'(e.sop));
        end
      end
      pv = ds_valid; prdy = ds_ready; pdata = ds_data; psof = ds_sof;
    end
  end

  // driver: pushes expectations from the requirements, then drives
  task automatic send_frame(input int tag, input int sel, input int keep, input int nch,
                            input int nref, input int rdel, input int fwd_cap,
                            input int chg_at);
    int esel, len, lim, nfw, tend;
    esel = (sel == 3) ? 2 : sel;
    len  = (1 << LMIN) << esel;
    lim  = len << keep;
    nfw  = 0;
    for (int i = 0; i < nch; i++) begin
      if (i < lim) exp_ch.push_back({(i % len) == 0, chd(tag, i)});
      else begin
        if (fwd_cap < 0 || nfw < fwd_cap) exp_ds.push_back({nfw == 0, chd(tag, i)});
        nfw++;
      end
    end
    for (int j = 0; j < nref && j < lim; j++) exp_ref.push_back(rfd(tag, j));
    tend = (nch > rdel + nref) ? nch : rdel + nref;
    for (int t = 0; t < tend; t++) begin
      @(negedge clk);
      if (t == 0) begin
        drive0 = cyc;
        cfg_len_sel = 2'(sel);
        cfg_keep = 1'(keep);
      end
      if (t == chg_at) begin cfg_len_sel = 2'd0; cfg_keep = 1'b0; end
      up_valid  = (t < nch);
      up_sof    = (t == 0);
      up_data   = chd(tag, t);
      ref_valid = (t >= rdel) && (t - rdel < nref);
      ref_sof   = (t == rdel);
      ref_data  = rfd(tag, t - rdel);
    end
    @(negedge clk);
    up_valid = 0; up_sof = 0; ref_valid = 0; ref_sof = 0;
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_len_sel = 0; cfg_keep = 0;
    up_valid = 0; up_sof = 0; up_data = '0;
    ref_valid = 0; ref_sof = 0; ref_data = '0;
    do_reset();
    #1;
    // R1 reset state
    chk(!loc_valid && !loc_sop, "R1", "local idle after reset", int'(loc_valid), 0);
    chk(!ds_valid && !ds_sof, "R1", "downstream idle after reset", int'(ds_valid), 0);
    chk(!err_fwd_ovf && !err_align_ovf, "R1", "errors clear after reset",
        int'({err_fwd_ovf, err_align_ovf}), 0);

    // R8 samples before any frame start are dropped
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      up_valid = 1; up_sof = 0; up_data = chd(99, t);
      ref_valid = 1; ref_sof = 0; ref_data = rfd(99, t);
    end
    @(negedge clk); up_valid = 0; ref_valid = 0;
    repeat (10) @(negedge clk);
    chk(loc_cnt == 0 && ds_cnt == 0, "R8", "no output before frame start", loc_cnt + ds_cnt, 0);

    // frame A: R2 R3 R9, surplus reference samples discarded (R8)
    first_loc = -1;
    send_frame(1, 0, 0, 20, 11, 0, -1, -1);
    drain();
    chk(first_loc - drive0 == 2, "R9", "pair latency, aligned", first_loc - drive0, 2);
    chk(exp_ch.size() == 0 && exp_ds.size() == 0, "R2", "frame A fully delivered",
        exp_ch.size() + exp_ds.size(), 0);
    chk(exp_ref.size() == 0, "R8", "extra reference discarded", exp_ref.size(), 0);

    // frame B: R4 two pulses, R5 code 1, reference late by 3, R10 toggling ready
    rdy_mode = 1;
    first_loc = -1;
    send_frame(2, 1, 1, 38, 32, 3, -1, -1);
    drain();
    rdy_mode = 0;
    chk(first_loc - drive0 == 5, "R9", "pair latency, late reference", first_loc - drive0, 5);
    chk(exp_ch.size() == 0 && exp_ds.size() == 0, "R4", "two pulses kept",
        exp_ch.size() + exp_ds.size(), 0);
    chk(!err_fwd_ovf && !err_align_ovf, "R11", "no false overflow",
        int'({err_fwd_ovf, err_align_ovf}), 0);

    // frame C: R5 code 3 acts as code 2, R6 mid-frame config change ignored
    send_frame(3, 3, 0, 36, 32, 0, -1, 2);
    drain();
    chk(exp_ch.size() == 0 && exp_ds.size() == 0, "R6", "config held for frame",
        exp_ch.size() + exp_ds.size(), 0);

    // R7 restart inside local part and inside forwarded part
    send_frame(4, 0, 1, 5, 5, 0, -1, -1);
    send_frame(5, 0, 0, 12, 8, 0, -1, -1);
    send_frame(6, 0, 0, 10, 8, 0, -1, -1);
    drain();
    chk(exp_ch.size() == 0 && exp_ds.size() == 0 && exp_ref.size() == 0, "R7",
        "restarted frames delivered", exp_ch.size() + exp_ds.size(), 0);

    // R11 overflow of the forwarding FIFO while stalled
    rdy_mode = 2;
    send_frame(7, 0, 0, 14, 8, 0, FD, -1);
    repeat (5) @(negedge clk);
    #1;
    chk(err_fwd_ovf, "R11", "overflow flagged", int'(err_fwd_ovf), 1);
    chk(exp_ch.size() == 0, "R10", "local pairs not stalled", exp_ch.size(), 0);
    rdy_mode = 0;
    drain();
    #1;
    chk(exp_ds.size() == 0, "R11", "only stored samples forwarded", exp_ds.size(), 0);
    chk(err_fwd_ovf, "R11", "overflow flag sticky", int'(err_fwd_ovf), 1);

    // R12 alignment overflow: channel with no reference
    send_frame(8, 1, 0, AD + 2, 0, 0, -1, -1);
    repeat (4) @(negedge clk);
    #1;
    chk(err_align_ovf, "R12", "alignment overflow flagged", int'(err_align_ovf), 1);
    repeat (4) @(negedge clk);
    #1;
    chk(err_align_ovf, "R12", "alignment flag sticky", int'(err_align_ovf), 1);
    do_reset();
    exp_ch.delete(); exp_ref.delete(); exp_ds.delete();
    #1;
    chk(!err_fwd_ovf && !err_align_ovf && !loc_valid && !ds_valid, "R1",
        "second reset clears state", int'({err_fwd_ovf, err_align_ovf}), 0);

    finish_run();
  end
endmodule